// File: doc/BRIEF.md
# Single-Pin OOK Transmit Sequencer

This block runs the transmit state of an on-off-keyed radio front end that has no command interface. A single data pin does two jobs: a rising edge on it while the radio sleeps wakes the transmitter, and once the transmitter is running the same pin carries the OOK bit stream. The synthesiser and the calibration engine sit outside this block. The sequencer only raises their enables, times each phase, and gates the power-amplifier output.

After a wake edge the block calibrates for a fixed number of clocks, then waits a fixed number of clocks for the PLL to settle, and then enters transmit. In transmit the amplifier output follows the synchronized pin, so OOK data at 1 to 20 kbps passes straight through. A run of low level longer than a timeout of roughly 20 ms sends the block back to sleep by itself. The timeout is derived from the clock frequency and a time in microseconds, both given as parameters.

Top module: `ook_wake_seq`

## Requirements
- R1: While reset is asserted (synchronous, active high) the state output reads sleep (code 0), and `cal_en`, `pll_en` and `pa_out` are all low.
- R2: The state code on `state_o` is 0 for sleep, 1 for calibrate, 2 for PLL settle and 3 for transmit. A rising edge on `pin_in` while in sleep puts `state_o` at calibrate on the SYNC_STAGES+1-th rising clock edge after the pin rises.
- R3: Calibrate lasts exactly CAL_CYCLES clocks, and `cal_en` is high in calibrate and in no other state.
- R4: PLL settle follows calibrate and lasts exactly PLL_CYCLES clocks before transmit. `pll_en` is high in PLL settle and in transmit, and low otherwise.
- R5: In transmit, `pa_out` equals `pin_in` delayed by SYNC_STAGES clocks. In every other state `pa_out` is low.
- R6: Pin edges during calibrate and PLL settle are ignored: they change neither the state nor the length of either phase.
- R7: In transmit, once the synchronized pin has been low for IDLE_CYCLES = (CLK_HZ/1000000)*TIMEOUT_US consecutive clocks, the block enters sleep. This happens on the SYNC_STAGES+IDLE_CYCLES-th clock edge after the pin falls.
- R8: Any high sample in transmit restarts the low-time count, so low runs shorter than IDLE_CYCLES never leave transmit, however many of them come in a row.
- R9: In sleep with the pin held low the block stays in sleep, and state changes only ever step forward by one code (0, 1, 2, 3, then back to 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 1 | Asynchronous wake and OOK data pin |
| state_o | output | 2 | State code: 0 sleep, 1 calibrate, 2 PLL settle, 3 transmit |
| cal_en | output | 1 | Calibration enable |
| pll_en | output | 1 | Synthesiser enable |
| pa_out | output | 1 | Power-amplifier keying output |

## Verification
The bench sweeps the length of a low run in transmit from one clock up to two past the timeout, and predicts every cycle of state and amplifier output. An off-by-one in the low counter would leave sleep one clock early or late, and a counter that does not restart on high would drop out of transmit after a series of short gaps. It toggles the pin throughout calibration and settling: a design that listened to those edges would restart or shorten the phases and reach transmit at the wrong clock. It also resets mid-transmit with the pin high, and holds the pin low in sleep, to catch enables that leak out of reset and wakes that happen with no edge.

// File: rtl/ookseq_pkg.sv
package ookseq_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP  = 2'd0,
    ST_CAL    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_TX     = 2'd3
  } seq_state_e;

  // Number of clocks in the low-time window.
  function automatic int unsigned idle_cycles(input int unsigned clk_hz,
                                              input int unsigned timeout_us);
    return (clk_hz / 1000000) * timeout_us;
  endfunction

  // Bits needed by a counter that runs from 0 to n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         run,
  input  logic [W-1:0] last,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (run)       cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == last);

endmodule

// File: rtl/idle_watch.sv
module idle_watch #(
  parameter int LIMIT = 20000,
  parameter int W     = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic active,
  input  logic lvl,
  output logic hit
);

  logic [W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || lvl) low_cnt <= '0;
    else if (active)           low_cnt <= low_cnt + 1'b1;
  end

  assign hit = active && !lvl && (low_cnt == W'(LIMIT - 1));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import ookseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wake,
  input  logic       phase_done,
  input  logic       idle_hit,
  output seq_state_e st,
  output logic       restart
);

  seq_state_e nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_SLEEP:  if (wake)       nxt = ST_CAL;
      ST_CAL:    if (phase_done) nxt = ST_SETTLE;
      ST_SETTLE: if (phase_done) nxt = ST_TX;
      ST_TX:     if (idle_hit)   nxt = ST_SLEEP;
      default:                   nxt = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_SLEEP;
    else     st <= nxt;
  end

  assign restart = (nxt != st);

endmodule

// File: rtl/ook_wake_seq.sv
module ook_wake_seq
  import ookseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CAL_CYCLES  = 64,
  parameter int PLL_CYCLES  = 256,
  parameter int CLK_HZ      = 1000000,
  parameter int TIMEOUT_US  = 20000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_in,
  output logic [1:0] state_o,
  output logic       cal_en,
  output logic       pll_en,
  output logic       pa_out
);

  localparam int IDLE_CYCLES = int'(idle_cycles(CLK_HZ, TIMEOUT_US));
  localparam int PH_W        = int'(cnt_width(max2(CAL_CYCLES, PLL_CYCLES)));
  localparam int IDLE_W      = int'(cnt_width(IDLE_CYCLES));

  logic       pin_lvl;
  logic       wake_rise;
  logic       phase_done;
  logic       idle_hit;
  logic       restart;
  logic       phase_run;
  logic       in_tx;
  logic [PH_W-1:0] phase_last;
  seq_state_e st;

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin (pin_in),
    .lvl (pin_lvl),
    .rise(wake_rise)
  );

  assign phase_run  = (st == ST_CAL) || (st == ST_SETTLE);
  assign phase_last = (st == ST_CAL) ? PH_W'(CAL_CYCLES - 1) : PH_W'(PLL_CYCLES - 1);
  assign in_tx      = (st == ST_TX);

  phase_timer #(.W(PH_W)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .run    (phase_run),
    .last   (phase_last),
    .done   (phase_done)
  );

  idle_watch #(.LIMIT(IDLE_CYCLES), .W(IDLE_W)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .active (in_tx),
    .lvl    (pin_lvl),
    .hit    (idle_hit)
  );

  seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wake      (wake_rise),
    .phase_done(phase_done),
    .idle_hit  (idle_hit),
    .st        (st),
    .restart   (restart)
  );

  assign state_o = st;
  assign cal_en  = (st == ST_CAL);
  assign pll_en  = (st == ST_SETTLE) || in_tx;
  assign pa_out  = in_tx && pin_lvl;

endmodule

// File: rtl/ook_wake_seq_chk.sv
module ook_wake_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] st,
  input logic       cal_en,
  input logic       pll_en,
  input logic       pa_out,
  input logic       rise,
  input logic       phase_done,
  input logic       idle_hit
);

  // R2: a wake edge seen in sleep moves to calibrate
  a_r2_wake: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0 && rise) |=> (st == 2'd1));

  // R3: calibration enable only in calibrate
  a_r3_cal_only: assert property (@(posedge clk) disable iff (rst)
    cal_en |-> (st == 2'd1));

  // R4: synthesiser stays enabled through settle and transmit
  a_r4_pll_on: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd2 || st == 2'd3) |-> pll_en);

  // R5: amplifier keyed only in transmit
  a_r5_pa_tx: assert property (@(posedge clk) disable iff (rst)
    pa_out |-> (st == 2'd3));

  // R6: calibrate holds until its own timer ends, whatever the pin does
  a_r6_hold_cal: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1 && !phase_done) |=> (st == 2'd1));

  // R7: low-time expiry returns to sleep
  a_r7_exit: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd3 && idle_hit) |=> (st == 2'd0));

  // R8: no expiry, no exit
  a_r8_stay: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd3 && !idle_hit) |=> (st == 2'd3));

  // R9: states only step forward by one
  a_r9_order: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (st == $past(st) || st == $past(st) + 2'd1));

endmodule

bind ook_wake_seq ook_wake_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .st        (state_o),
  .cal_en    (cal_en),
  .pll_en    (pll_en),
  .pa_out    (pa_out),
  .rise      (wake_rise),
  .phase_done(phase_done),
  .idle_hit  (idle_hit)
);

// File: tb/sim_ook_wake_seq.sv
module sim_ook_wake_seq;

  localparam int CLK_PERIOD = 10;
  localparam int S    = 2;
  localparam int CAL  = 5;
  localparam int PLL  = 7;
  localparam int IDLE = 12;   // CLK_HZ 1 MHz, 12 us

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b0;
  logic [1:0] state_o;
  logic       cal_en, pll_en, pa_out;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ook_wake_seq #(
    .SYNC_STAGES(S), .CAL_CYCLES(CAL), .PLL_CYCLES(PLL),
    .CLK_HZ(1000000), .TIMEOUT_US(IDLE)
  ) u0 (
    .clk(clk), .rst(rst), .pin_in(pin),
    .state_o(state_o), .cal_en(cal_en), .pll_en(pll_en), .pa_out(pa_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected state k clock edges after the pin rises in sleep.
  function automatic int wake_state(input int k);
    if (k <= S)             return 0;
    if (k <= S + CAL)       return 1;
    if (k <= S + CAL + PLL) return 2;
    return 3;
  endfunction

  task automatic check_outputs(input string req, input int exp_st, input int exp_pa);
    chk(req, state_o, exp_st);
    chk({req, "_cal_en R3"}, cal_en, (exp_st == 1) ? 1 : 0);
    chk({req, "_pll_en R4"}, pll_en, (exp_st >= 2) ? 1 : 0);
    chk({req, "_pa R5"},     pa_out, (exp_st == 3) ? exp_pa : 0);
  endtask

  // R2 R3 R4 R6: wake; toggling pin through the phases if asked
  task automatic wake(input bit toggle);
    int tog_end = CAL + PLL - 2;
    @(negedge clk) pin = 1'b1;
    for (int k = 1; k <= S + CAL + PLL + 3; k++) begin
      @(posedge clk); #1;
      check_outputs(toggle ? "R6_wake_toggle" : "R2_wake", wake_state(k), 1);
      if (toggle) begin
        @(negedge clk);
        pin = (k >= S + 1 && k <= tog_end) ? k[0] : 1'b1;
      end
    end
  endtask

  // R7 R8 R5: low run of L clocks in transmit
  task automatic low_run(input int L);
    bit exits = (L >= IDLE);
    @(negedge clk) pin = 1'b0;
    for (int k = 1; k <= L + S + 1; k++) begin
      int est;
      int epa;
      @(posedge clk); #1;
      if (!exits || k < S + IDLE) est = 3;
      else if (k <= L + S)        est = 0;
      else                        est = 1;
      epa = (k >= S && k <= L + S - 1) ? 0 : 1;
      check_outputs(exits ? "R7_low_run" : "R8_low_run", est, epa);
      if (k == L) begin
        @(negedge clk) pin = 1'b1;
      end
    end
    if (exits) begin
      repeat (CAL + PLL) @(posedge clk);
      #1 chk("R7_rewake_tx", state_o, 3);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 check_outputs("R1_reset", 0, 0);
    @(negedge clk) rst = 1'b0;

    // R9: idle low in sleep stays asleep
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1 chk("R9_sleep_hold", state_o, 0);
    end

    wake(1'b0);
    for (int L = 1; L <= IDLE + 2; L++) low_run(L);

    // R8: repeated short gaps separated by single highs
    for (int c = 0; c < 4 * IDLE; c++) begin
      @(negedge clk) pin = ((c % IDLE) == IDLE - 1) ? 1'b1 : 1'b0;
      @(posedge clk); #1 chk("R8_short_gaps", state_o, 3);
    end
    @(negedge clk) pin = 1'b1;
    repeat (S + 1) @(posedge clk);

    // R7 to sleep with pin low, then R6 wake with toggling
    @(negedge clk) pin = 1'b0;
    repeat (S + IDLE + 2) @(posedge clk);
    #1 chk("R7_sleep_reached", state_o, 0);
    wake(1'b1);

    // R1: reset during transmit with the pin high
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1 check_outputs("R1_reset_in_tx", 0, 0);
    @(negedge clk) begin pin = 1'b0; rst = 1'b0; end
    repeat (5) @(posedge clk);
    #1 chk("R1_after_reset_sleep", state_o, 0);

    // second wake from a different phase of the cycle
    @(negedge clk);
    wake(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule